// File: doc/BRIEF.md
# Dual-Compare PWM Output Channel

This block drives one pulse-width-modulated pin from two equality comparators that watch a free-running time-base bus supplied from outside. The lead comparator opens a pulse and the trail comparator closes it. Software loads the trail value into a front register. A hidden shadow register follows the front register only while the output is low, so a new trail value never cuts short a pulse that is already running.

A three-bit mask selector makes both comparators ignore the upper bits of the time base. This gives eight pulse periods from one time base. The output level can be forced high or low by software strobes. A sticky flag records each leading-edge compare and is cleared by its own strobe. A polarity bit chooses whether the pin shows the internal level as it is or inverted.

Software reaches the block through a single-cycle write port and a read port with one cycle of latency. Address 0 is the lead value. Address 1 is the trail front register. Address 2 is the control word:
- bits [3:0]: mode, where bit 3 enables PWM and bits [2:0] select the mask;
- bit 4: polarity;
- bit 5: force-high strobe;
- bit 6: force-low strobe;
- bit 7: flag-clear strobe.

When address 2 is read, the level appears in bit 8 and the flag in bit 9. The strobe bits read back as 0.

Top module: `dcp_pwm_channel`

## Requirements
- R1: After reset the level, flag and pin are 0, and the lead, trail and control registers read back as 0. PWM mode is off.
- R2: While mode bit 3 is 0, time-base values equal to the lead or trail value change neither the level nor the flag.
- R3: In PWM mode, a time-base value equal to the lead value in cycle t sets the level and the flag from cycle t+1.
- R4: In PWM mode, a time-base value equal to the shadow value clears the level on the next cycle and never sets the flag.
- R5: The shadow register copies the trail front register only on cycles that begin with the level low. A trail write made during a pulse leaves that pulse's trailing edge unchanged and takes effect for the next pulse.
- R6: Mask selector N (control bits [2:0]) makes both comparators ignore the top N of 16 time-base bits, so pulses repeat every 2^(16-N) ticks.
- R7: The pin equals the level XOR the polarity bit (control bit 4) in every cycle.
- R8: The force-high strobe (bit 5) sets the level and the force-low strobe (bit 6) clears it on the next cycle, in any mode. Force-low wins if both are given. Neither strobe changes the flag.
- R9: The flag-clear strobe (bit 7) clears the flag. A lead match in the same cycle wins and leaves the flag set.
- R10: If the lead and shadow matches fall in the same cycle, the level ends low.
- R11: Pulses keep being produced on every compare whether the flag is set or clear.
- R12: Read data appears one cycle after the read address: the lead value at address 0, the trail front value at address 1, and the control word with level in bit 8 and flag in bit 9 at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbase_i | input | 16 | Time-base bus value |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 16 | Registered read data |
| flag_o | output | 1 | Sticky leading-edge compare flag |
| level_o | output | 1 | Internal output level |
| pwm_o | output | 1 | PWM pin after polarity |

## Verification
Two functions can fall in one cycle, and the bench provokes each pairing on purpose.

The first pairing is the lead match and the flag-clear strobe. The bench writes the control word with the clear bit while the time base sits on the lead value, then expects the flag to remain set.

The second pairing is the lead and trail matches. The bench makes the shadow equal to the lead value, presents that value once, and expects the level to stay low while the flag still rises.

Force strobes given together are judged the same way: the level must end low and the flag must keep its value.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  // register selector used by the write and read ports
  typedef enum logic [1:0] {
    REG_LEAD  = 2'd0,
    REG_TRAIL = 2'd1,
    REG_CTRL  = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;

  // one-cycle software strobes decoded from a control write
  typedef struct packed {
    logic fset;
    logic fclr;
    logic flag_clr;
  } strobe_t;
endpackage

// File: rtl/dcp_regs.sv
module dcp_regs
  import dcp_pkg::*;
#(
  parameter int TB_W  = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [TB_W-1:0]  wr_data_i,
  input  logic [1:0]       rd_addr_i,
  input  logic             level_i,
  input  logic             flag_i,
  output logic [TB_W-1:0]  lead_o,
  output logic [TB_W-1:0]  trail_o,
  output logic             mode_en_o,
  output logic [SEL_W-1:0] mask_sel_o,
  output logic             pol_o,
  output logic             pol_nxt_o,
  output strobe_t          strobe_o,
  output logic [TB_W-1:0]  rd_data_o
);
  localparam int MODE_W   = SEL_W + 1;
  localparam int POL_BIT  = MODE_W;
  localparam int FSET_BIT = MODE_W + 1;
  localparam int FCLR_BIT = MODE_W + 2;
  localparam int FLCL_BIT = MODE_W + 3;
  localparam int LVL_BIT  = MODE_W + 4;
  localparam int FLAG_BIT = MODE_W + 5;

  logic [TB_W-1:0]   lead_r, trail_r, ctl_view, rd_nxt;
  logic [MODE_W-1:0] mode_r;
  logic              pol_r, ctl_wr;

  assign ctl_wr = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      lead_r  <= '0;
      trail_r <= '0;
      mode_r  <= '0;
      pol_r   <= 1'b0;
    end else if (wr_en_i) begin
      unique case (reg_sel_e'(wr_addr_i))
        REG_LEAD:  lead_r  <= wr_data_i;
        REG_TRAIL: trail_r <= wr_data_i;
        REG_CTRL: begin
          mode_r <= wr_data_i[MODE_W-1:0];
          pol_r  <= wr_data_i[POL_BIT];
        end
        default: ;
      endcase
    end
  end

  // polarity as it will be after this edge, so the pin register stays aligned
  always_comb begin
    pol_nxt_o = pol_r;
    if (ctl_wr) pol_nxt_o = wr_data_i[POL_BIT];
  end

  assign strobe_o.fset     = ctl_wr && wr_data_i[FSET_BIT];
  assign strobe_o.fclr     = ctl_wr && wr_data_i[FCLR_BIT];
  assign strobe_o.flag_clr = ctl_wr && wr_data_i[FLCL_BIT];

  always_comb begin
    ctl_view                = '0;
    ctl_view[MODE_W-1:0]    = mode_r;
    ctl_view[POL_BIT]       = pol_r;
    ctl_view[LVL_BIT]       = level_i;
    ctl_view[FLAG_BIT]      = flag_i;
  end

  always_comb begin
    unique case (reg_sel_e'(rd_addr_i))
      REG_LEAD:  rd_nxt = lead_r;
      REG_TRAIL: rd_nxt = trail_r;
      REG_CTRL:  rd_nxt = ctl_view;
      default:   rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_nxt;
  end

  assign lead_o     = lead_r;
  assign trail_o    = trail_r;
  assign mode_en_o  = mode_r[MODE_W-1];
  assign mask_sel_o = mode_r[SEL_W-1:0];
  assign pol_o      = pol_r;
endmodule

// File: rtl/dcp_match.sv
module dcp_match #(
  parameter int TB_W  = 16,
  parameter int SEL_W = 3
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [TB_W-1:0]  tbase_i,
  input  logic [TB_W-1:0]  ref_i,
  output logic             hit_o
);
  logic [TB_W-1:0] care, same;

  // the selector drops that many bits from the top of the compare
  assign care = {TB_W{1'b1}} >> sel_i;

  for (genvar i = 0; i < TB_W; i++) begin : g_bit
    assign same[i] = ~care[i] | (tbase_i[i] ~^ ref_i[i]);
  end

  assign hit_o = en_i & (&same);
endmodule

// File: rtl/dcp_edge.sv
module dcp_edge #(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hit_lead_i,
  input  logic            hit_trail_i,
  input  logic            fset_i,
  input  logic            fclr_i,
  input  logic            flag_clr_i,
  input  logic            pol_nxt_i,
  input  logic [TB_W-1:0] trail_front_i,
  output logic            level_o,
  output logic            flag_o,
  output logic            pwm_o,
  output logic [TB_W-1:0] shadow_o
);
  logic lvl_d, flag_d;

  // later lines win: lead < trail < force-high < force-low
  always_comb begin
    lvl_d = level_o;
    if (hit_lead_i)  lvl_d = 1'b1;
    if (hit_trail_i) lvl_d = 1'b0;
    if (fset_i)      lvl_d = 1'b1;
    if (fclr_i)      lvl_d = 1'b0;
  end

  always_comb begin
    flag_d = flag_o;
    if (flag_clr_i) flag_d = 1'b0;
    if (hit_lead_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o  <= 1'b0;
      flag_o   <= 1'b0;
      pwm_o    <= 1'b0;
      shadow_o <= '0;
    end else begin
      level_o <= lvl_d;
      flag_o  <= flag_d;
      pwm_o   <= lvl_d ^ pol_nxt_i;
      if (!level_o) shadow_o <= trail_front_i;
    end
  end
endmodule

// File: rtl/dcp_pwm_channel.sv
module dcp_pwm_channel
  import dcp_pkg::*;
#(
  parameter int TB_W  = 16,
  parameter int SEL_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TB_W-1:0] tbase_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_addr_i,
  input  logic [TB_W-1:0] wr_data_i,
  input  logic [1:0]      rd_addr_i,
  output logic [TB_W-1:0] rd_data_o,
  output logic            flag_o,
  output logic            level_o,
  output logic            pwm_o
);
  logic [TB_W-1:0]  lead_val, trail_front, trail_shadow;
  logic             mode_en, pol_q, pol_nxt;
  logic [SEL_W-1:0] mask_sel;
  strobe_t          strb;
  logic             frc_set, frc_clr, flag_clr;
  logic             hit_lead, hit_trail;

  dcp_regs #(.TB_W(TB_W), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .level_i   (level_o),
    .flag_i    (flag_o),
    .lead_o    (lead_val),
    .trail_o   (trail_front),
    .mode_en_o (mode_en),
    .mask_sel_o(mask_sel),
    .pol_o     (pol_q),
    .pol_nxt_o (pol_nxt),
    .strobe_o  (strb),
    .rd_data_o (rd_data_o)
  );

  assign frc_set  = strb.fset;
  assign frc_clr  = strb.fclr;
  assign flag_clr = strb.flag_clr;

  dcp_match #(.TB_W(TB_W), .SEL_W(SEL_W)) u_lead_cmp (
    .en_i   (mode_en),
    .sel_i  (mask_sel),
    .tbase_i(tbase_i),
    .ref_i  (lead_val),
    .hit_o  (hit_lead)
  );

  dcp_match #(.TB_W(TB_W), .SEL_W(SEL_W)) u_trail_cmp (
    .en_i   (mode_en),
    .sel_i  (mask_sel),
    .tbase_i(tbase_i),
    .ref_i  (trail_shadow),
    .hit_o  (hit_trail)
  );

  dcp_edge #(.TB_W(TB_W)) u_edge (
    .clk          (clk),
    .rst          (rst),
    .hit_lead_i   (hit_lead),
    .hit_trail_i  (hit_trail),
    .fset_i       (frc_set),
    .fclr_i       (frc_clr),
    .flag_clr_i   (flag_clr),
    .pol_nxt_i    (pol_nxt),
    .trail_front_i(trail_front),
    .level_o      (level_o),
    .flag_o       (flag_o),
    .pwm_o        (pwm_o),
    .shadow_o     (trail_shadow)
  );
endmodule

// File: rtl/dcp_checker.sv
module dcp_checker #(
  parameter int TB_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic            hit_a,
  input logic            hit_b,
  input logic            fset,
  input logic            fclr,
  input logic            flag_clr,
  input logic            level,
  input logic            flag,
  input logic            pwm,
  input logic            pol,
  input logic [TB_W-1:0] b1,
  input logic [TB_W-1:0] b2
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !fset && !fclr) |=> $stable(level));
  // R2
  idle_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !$rose(flag));
  // R3
  lead_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_a && !hit_b && !fclr) |=> (level && flag));
  // R4
  trail_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_b && !fset) |=> !level);
  // R4
  trail_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit_a && !flag) |=> !flag);
  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    level |=> $stable(b2));
  // R5
  shadow_load_chk: assert property (@(posedge clk) disable iff (rst)
    !level |=> (b2 == $past(b1)));
  // R7
  polarity_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (pwm == (level ^ pol)));
  // R8
  force_high_chk: assert property (@(posedge clk) disable iff (rst)
    (fset && !fclr) |=> level);
  // R8
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    fclr |=> !level);
  // R8
  force_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ((fset || fclr) && !hit_a && !flag_clr) |=> $stable(flag));
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !hit_a) |=> !flag);
  // R10
  coincide_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_a && hit_b && !fset) |=> !level);
endmodule

bind dcp_pwm_channel dcp_checker #(.TB_W(TB_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (mode_en),
  .hit_a   (hit_lead),
  .hit_b   (hit_trail),
  .fset    (frc_set),
  .fclr    (frc_clr),
  .flag_clr(flag_clr),
  .level   (level_o),
  .flag    (flag_o),
  .pwm     (pwm_o),
  .pol     (pol_q),
  .b1      (trail_front),
  .b2      (trail_shadow)
);

// File: tb/tb_dcp_pwm_channel.sv
module tb_dcp_pwm_channel;
  localparam int TW = 16;
  localparam logic [TW-1:0] PARK = 16'hF000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] tbase = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [TW-1:0] wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [TW-1:0] rd_data;
  logic          flag_o, level_o, pwm_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dcp_pwm_channel dut (
    .clk(clk), .rst(rst), .tbase_i(tbase), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .flag_o(flag_o), .level_o(level_o), .pwm_o(pwm_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [TW-1:0] t);
    tbase = t;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [TW-1:0] d, input logic [TW-1:0] t);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tbase = t;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // control: mode[3:0], pol bit4, force-high bit5, force-low bit6, flag-clear bit7
  task automatic ctl(input logic [3:0] mode, input logic pol, input logic fs, input logic fc,
                     input logic clr, input logic [TW-1:0] t);
    wr(2'd2, {8'h00, clr, fc, fs, pol, mode}, t);
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [TW-1:0] exp);
    rd_addr = a; tbase = PARK;
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 level after reset", level_o, 0);
    chk("R1 flag after reset", flag_o, 0);
    chk("R1 pin after reset", pwm_o, 0);
    rd(2'd0, "R1 lead reads 0", 16'h0);
    rd(2'd1, "R1 trail reads 0", 16'h0);
    rd(2'd2, "R1 control reads 0", 16'h0);
  endtask

  task automatic t_idle();
    wr(2'd0, 16'h0010, PARK);
    wr(2'd1, 16'h0020, PARK);
    cyc(16'h0010);
    chk("R2 no lead effect when off", level_o, 0);
    chk("R2 no flag when off", flag_o, 0);
    cyc(16'h0020);
    chk("R2 no trail effect when off", level_o, 0);
    rd(2'd0, "R12 lead readback", 16'h0010);
    rd(2'd1, "R12 trail readback", 16'h0020);
  endtask

  task automatic t_lead_trail();
    ctl(4'h8, 0, 0, 0, 0, PARK);
    cyc(16'h000F);
    chk("R3 no edge before match", level_o, 0);
    cyc(16'h0010);
    chk("R3 lead sets level", level_o, 1);
    chk("R3 lead sets flag", flag_o, 1);
    chk("R7 pin follows level", pwm_o, 1);
    cyc(16'h0011);
    chk("R3 level holds", level_o, 1);
    cyc(16'h0020);
    chk("R4 trail clears level", level_o, 0);
    ctl(4'h8, 0, 0, 0, 1, PARK);
    chk("R9 clear strobe", flag_o, 0);
    cyc(16'h0020);
    chk("R4 trail leaves flag clear", flag_o, 0);
    cyc(16'h0010);
    cyc(16'h0020);
    cyc(16'h0010);
    chk("R11 pulse with flag set", level_o, 1);
    chk("R11 flag still set", flag_o, 1);
    cyc(16'h0020);
    chk("R11 pulse ends", level_o, 0);
  endtask

  task automatic t_shadow();
    cyc(16'h0010);
    chk("R5 pulse open", level_o, 1);
    wr(2'd1, 16'h0030, PARK);
    cyc(16'h0020);
    chk("R5 old trail used mid-pulse", level_o, 0);
    cyc(16'h0010);
    cyc(16'h0020);
    chk("R5 old trail dropped", level_o, 1);
    cyc(16'h0030);
    chk("R5 new trail used", level_o, 0);
  endtask

  task automatic t_coincide();
    wr(2'd1, 16'h0010, PARK);
    cyc(PARK);
    ctl(4'h8, 0, 0, 0, 1, PARK);
    cyc(16'h0010);
    chk("R10 coincident stays low", level_o, 0);
    chk("R10 flag still set", flag_o, 1);
    wr(2'd1, 16'h0020, PARK);
    cyc(PARK);
  endtask

  task automatic t_flag_race();
    ctl(4'h8, 0, 0, 0, 1, PARK);
    chk("R9 flag cleared", flag_o, 0);
    ctl(4'h8, 0, 0, 0, 1, 16'h0010);
    chk("R9 set wins over clear", flag_o, 1);
    cyc(16'h0020);
    ctl(4'h8, 0, 0, 0, 1, PARK);
    chk("R9 clear alone", flag_o, 0);
  endtask

  task automatic t_force();
    ctl(4'h0, 0, 1, 0, 0, PARK);
    chk("R8 force high", level_o, 1);
    chk("R8 flag kept clear", flag_o, 0);
    ctl(4'h0, 0, 0, 1, 0, PARK);
    chk("R8 force low", level_o, 0);
    ctl(4'h8, 0, 0, 0, 0, PARK);
    cyc(16'h0010);
    chk("R8 flag set by compare", flag_o, 1);
    ctl(4'h0, 0, 0, 1, 0, PARK);
    chk("R8 force low mid-pulse", level_o, 0);
    chk("R8 flag kept set", flag_o, 1);
    ctl(4'h0, 0, 1, 1, 0, PARK);
    chk("R8 both strobes give low", level_o, 0);
    chk("R8 flag unchanged by both", flag_o, 1);
  endtask

  task automatic t_polarity();
    ctl(4'h0, 1, 0, 0, 0, PARK);
    chk("R7 inverted low level", pwm_o, 1);
    ctl(4'h0, 1, 1, 0, 0, PARK);
    chk("R7 inverted high level", pwm_o, 0);
    ctl(4'h0, 0, 0, 1, 0, PARK);
    chk("R7 direct low level", pwm_o, 0);
    rd(2'd2, "R12 status flag bit9", 16'h0200);
    ctl(4'h0, 0, 1, 0, 0, PARK);
    rd(2'd2, "R12 status level bit8", 16'h0300);
  endtask

  task automatic sweep(input int n, output int rises);
    logic prev;
    rises = 0;
    prev = level_o;
    for (int i = 0; i < n; i++) begin
      cyc(TW'(i));
      if (level_o && !prev) rises++;
      prev = level_o;
    end
  endtask

  task automatic t_mask();
    int r;
    ctl(4'h0, 0, 0, 1, 1, PARK);
    wr(2'd0, 16'h0003, PARK);
    wr(2'd1, 16'h0008, PARK);
    cyc(PARK);
    ctl(4'hF, 0, 0, 0, 0, PARK);
    cyc(16'hFE03);
    chk("R6 masked lead match", level_o, 1);
    cyc(16'h7E08);
    chk("R6 masked trail match", level_o, 0);
    ctl(4'h8, 0, 0, 0, 0, PARK);
    cyc(16'hFE03);
    chk("R6 unmasked no match", level_o, 0);
    ctl(4'hF, 0, 0, 0, 0, PARK);
    sweep(1024, r);
    chk("R6 N=7 pulses in 1024 ticks", r, 2);
    ctl(4'h8, 0, 0, 0, 0, PARK);
    sweep(1024, r);
    chk("R6 N=0 pulses in 1024 ticks", r, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_lead_trail();
    t_shadow();
    t_coincide();
    t_flag_race();
    t_force();
    t_polarity();
    t_mask();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule